// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Comparator

This block is one debug break channel. It watches every processor bus cycle and raises a single-clock break pulse when the cycle meets all of the conditions software has set up. A cycle is judged on four things: its address, compared under a coarse mask; its access kind, which is instruction fetch or operand; its direction, which is read or write; and its operand size.

Software sets up the channel through a small register port. Three registers are selected by `reg_sel`. Selector 0 holds the 32-bit break address. Selector 1 holds a 3-bit mask code. Selector 2 holds a 16-bit condition word. Selector 3 reads as zero and ignores writes. Writes take effect at the clock edge. Reads are combinational. The registers are cleared only by the power-on reset, and no other state of the device disturbs them. Trap or exception handling after a match is left to the surrounding logic.

Top module: `bus_break_unit`

## Requirements
- R1: After power-on reset, all three registers read as zero and `brk_match` is low.
- R2: In the condition word (selector 2), bits 15:7 always read as zero and cannot be set by a write. Bits 6:0 are stored exactly as written.
- R3: Mask codes (selector 1, bits 2:0) decide how many low address bits are left out of the comparison: 000 leaves out none, 001 leaves out 10, 010 leaves out 12, 100 leaves out 16 and 101 leaves out 20. All remaining bits must equal the break address.
- R4: Mask code 011 leaves out every address bit, so the address never prevents a match.
- R5: A write of mask code 110 or 111 is refused, and the mask code held before the write stays in place.
- R6: The access-kind field (condition bits 5:4) works as follows: 00 means the field is off, 01 requires an instruction fetch (`bus_fetch`=1), 10 requires an operand access (`bus_fetch`=0), and 11 accepts either.
- R7: The direction field (condition bits 3:2) works as follows: 00 means the field is off, 01 requires a read (`bus_write`=0), 10 requires a write (`bus_write`=1), and 11 accepts either.
- R8: The size field is {bit 6, bits 1:0}. Code 000 ignores the size. Codes 001, 010, 011 and 100 require `bus_size` 0 (byte), 1 (word), 2 (longword) and 3 (quadword) respectively. Codes 101 to 111 never match.
- R9: `brk_match` is high in the clock after a qualifying cycle that has `bus_valid` high, for exactly one clock per such cycle. It never rises unless `bus_valid` was high in the cycle before.
- R10: While bits 6:0 of the condition word are all zero, the channel is disabled and never matches, whatever the mask code is.
- R11: A register write and a bus cycle in the same clock are handled as follows: the bus cycle is judged against the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 address, 1 mask code, 2 condition word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword, 3 quadword |
| brk_match | output | 1 | Registered break pulse |

## Verification
A register write and a bus cycle can land on the same clock edge. The bench provokes this by presenting a fetch cycle while, in that same clock, it rewrites the access-kind field so that only operand accesses would match. The comparison must use the old setting, so the bench expects a pulse. It then expects no pulse on the next fetch cycle, once the new setting is in place. The same pattern also exercises a refused mask-code write followed at once by a cycle whose match depends on the retained mask.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W  = 32;
  localparam int CC_W    = 16;
  localparam int CC_USED = 7;
  localparam int MCODE_W = 3;
  localparam int SIZE_W  = 2;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MASK = 2'd1,
    SEL_COND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Number of low address bits left out of the comparison for a mask code.
  function automatic int unsigned ignored_bits(input logic [MCODE_W-1:0] code);
    case (code)
      3'b001:  return 10;
      3'b010:  return 12;
      3'b011:  return ADDR_W;
      3'b100:  return 16;
      3'b101:  return 20;
      default: return 0;
    endcase
  endfunction

  // Bit i is set when address bit i takes part in the comparison.
  function automatic logic [ADDR_W-1:0] compare_mask(input logic [MCODE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    int unsigned n;
    n = ignored_bits(code);
    for (int i = 0; i < ADDR_W; i++) m[i] = (i >= n);
    return m;
  endfunction

  function automatic logic mask_code_legal(input logic [MCODE_W-1:0] code);
    return code[2:1] != 2'b11;
  endfunction

  // Two-bit selector: 00 off, 01 needs flag, 10 needs !flag, 11 either.
  function automatic logic sel_field_ok(input logic [1:0] f, input logic flag);
    case (f)
      2'b01:   return flag;
      2'b10:   return !flag;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic size_field_ok(input logic [2:0] code, input logic [SIZE_W-1:0] sz);
    case (code)
      3'b000:  return 1'b1;
      3'b001:  return sz == 2'd0;
      3'b010:  return sz == 2'd1;
      3'b011:  return sz == 2'd2;
      3'b100:  return sz == 2'd3;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [AW-1:0]       reg_wdata,
  output logic [AW-1:0]       reg_rdata,
  output logic [AW-1:0]       brk_addr,
  output logic [MCODE_W-1:0]  mask_code,
  output logic [CC_USED-1:0]  cond_bits,
  output logic                mask_refused
);
  reg_sel_e sel;
  logic wr_addr, wr_mask, wr_cond;

  assign sel          = reg_sel_e'(reg_sel);
  assign wr_addr      = reg_we && (sel == SEL_ADDR);
  assign wr_mask      = reg_we && (sel == SEL_MASK);
  assign wr_cond      = reg_we && (sel == SEL_COND);
  assign mask_refused = wr_mask && !mask_code_legal(reg_wdata[MCODE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr  <= '0;
      mask_code <= '0;
      cond_bits <= '0;
    end else begin
      if (wr_addr) brk_addr <= reg_wdata;
      if (wr_mask && !mask_refused) mask_code <= reg_wdata[MCODE_W-1:0];
      if (wr_cond) cond_bits <= reg_wdata[CC_USED-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_ADDR: reg_rdata = brk_addr;
      SEL_MASK: reg_rdata[MCODE_W-1:0] = mask_code;
      SEL_COND: reg_rdata[CC_USED-1:0] = cond_bits;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/brk_cond.sv
module brk_cond
  import brk_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]      brk_addr,
  input  logic [MCODE_W-1:0] mask_code,
  input  logic [CC_USED-1:0] cond_bits,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_fetch,
  input  logic               bus_write,
  input  logic [SIZE_W-1:0]  bus_size,
  output logic               chan_en,
  output logic               addr_ok,
  output logic               attr_ok
);
  logic [1:0] kind_f, dir_f;
  logic [2:0] size_f;
  logic [AW-1:0] keep;

  assign kind_f  = cond_bits[5:4];
  assign dir_f   = cond_bits[3:2];
  assign size_f  = {cond_bits[6], cond_bits[1:0]};
  assign chan_en = |cond_bits;

  assign keep    = AW'(compare_mask(mask_code));
  assign addr_ok = ((bus_addr ^ brk_addr) & keep) == '0;
  assign attr_ok = sel_field_ok(kind_f, bus_fetch)
                && sel_field_ok(dir_f, !bus_write)
                && size_field_ok(size_f, bus_size);
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [SIZE_W-1:0] bus_size,
  output logic              brk_match
);
  logic [ADDR_W-1:0]  brk_addr;
  logic [MCODE_W-1:0] mask_code;
  logic [CC_USED-1:0] cond_bits;
  logic               mask_refused;
  logic               chan_en, addr_ok, attr_ok, cycle_hit;

  brk_regs #(.AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_addr(brk_addr),
    .mask_code(mask_code), .cond_bits(cond_bits), .mask_refused(mask_refused)
  );

  brk_cond #(.AW(ADDR_W)) u_cond (
    .brk_addr(brk_addr), .mask_code(mask_code), .cond_bits(cond_bits),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_size(bus_size), .chan_en(chan_en), .addr_ok(addr_ok), .attr_ok(attr_ok)
  );

  assign cycle_hit = bus_valid && chan_en && addr_ok && attr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_match <= 1'b0;
    else        brk_match <= cycle_hit;
  end
endmodule

// File: rtl/brk_checker.sv
module brk_checker
  import brk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              bus_valid,
  input logic [MCODE_W-1:0] mask_code,
  input logic              chan_en,
  input logic              brk_match
);
  // R9: a pulse needs a valid bus cycle in the clock before
  assert_match_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_match);

  // R10: a disabled channel never pulses
  assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !brk_match);

  // R5: held mask code never takes a reserved value
  assert_mask_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_code[2:1] != 2'b11);

  // R5: refused write leaves the mask code unchanged
  assert_refused_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && reg_wdata[2:1] == 2'b11) |=> $stable(mask_code));

  // R2: reserved condition bits read as zero
  always @(posedge clk) begin
    if (rst_n && reg_sel == 2'd2)
      assert_cond_reserved_zero_R2: assert (reg_rdata[ADDR_W-1:CC_USED] == '0);
  end
endmodule

bind bus_break_unit brk_checker u_brk_checker (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
  .mask_code(mask_code), .chan_en(chan_en), .brk_match(brk_match)
);

// File: tb/tb_bus_break_unit.sv
module tb_bus_break_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_fetch = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic        brk_match;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] BASE = 32'h1234_5678;

  always #10 clk = ~clk;

  bus_break_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_size(bus_size), .brk_match(brk_match)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 check(tag, reg_rdata, exp);
  endtask

  // Present one bus cycle; brk_match is sampled at the next falling edge.
  task automatic cycle(input string tag, input logic [31:0] a, input logic f,
                       input logic w, input logic [1:0] s, input logic exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_fetch = f; bus_write = w; bus_size = s;
    @(negedge clk);
    bus_valid = 1'b0;
    check(tag, {31'd0, brk_match}, {31'd0, exp});
  endtask

  task automatic t_reset;
    read_check("R1 addr", 2'd0, 32'h0);
    read_check("R1 mask", 2'd1, 32'h0);
    read_check("R1 cond", 2'd2, 32'h0);
    check("R1 match", {31'd0, brk_match}, 32'h0);
    cycle("R10 reset disabled", 32'h0, 1'b1, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_reserved;
    write_reg(2'd2, 32'hFFFF_FFFF);
    read_check("R2 reserved", 2'd2, 32'h0000_007F);
    write_reg(2'd2, 32'h0000_FF80);
    read_check("R2 upper only", 2'd2, 32'h0);
  endtask

  task automatic t_disabled;
    write_reg(2'd1, 32'd3);
    write_reg(2'd2, 32'h0);
    cycle("R10 all off", 32'hDEAD_BEEF, 1'b0, 1'b1, 2'd1, 1'b0);
  endtask

  task automatic t_masks;
    write_reg(2'd0, BASE);
    write_reg(2'd2, 32'h30);
    write_reg(2'd1, 32'd3);
    cycle("R4 any addr", 32'h0000_0000, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R4 any addr2", 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd3, 1'b1);
    write_reg(2'd1, 32'd0);
    cycle("R3 exact hit", BASE, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R3 exact miss", BASE ^ 32'h1, 1'b1, 1'b0, 2'd0, 1'b0);
    write_reg(2'd1, 32'd1);
    cycle("R3 m10 hit", BASE ^ 32'h3FF, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R3 m10 miss", BASE ^ 32'h400, 1'b1, 1'b0, 2'd0, 1'b0);
    write_reg(2'd1, 32'd2);
    cycle("R3 m12 hit", BASE ^ 32'hFFF, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R3 m12 miss", BASE ^ 32'h1000, 1'b1, 1'b0, 2'd0, 1'b0);
    write_reg(2'd1, 32'd4);
    cycle("R3 m16 hit", BASE ^ 32'hFFFF, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R3 m16 miss", BASE ^ 32'h1_0000, 1'b1, 1'b0, 2'd0, 1'b0);
    write_reg(2'd1, 32'd5);
    cycle("R3 m20 hit", BASE ^ 32'hF_FFFF, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R3 m20 miss", BASE ^ 32'h10_0000, 1'b1, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_refused;
    write_reg(2'd1, 32'd5);
    write_reg(2'd1, 32'd6);
    read_check("R5 code 110", 2'd1, 32'd5);
    write_reg(2'd1, 32'd7);
    read_check("R5 code 111", 2'd1, 32'd5);
    cycle("R5 mask kept", BASE ^ 32'hF_FFFF, 1'b1, 1'b0, 2'd0, 1'b1);
  endtask

  task automatic t_fields;
    write_reg(2'd1, 32'd3);
    write_reg(2'd2, 32'h10);
    cycle("R6 fetch hit", 32'h0, 1'b1, 1'b0, 2'd0, 1'b1);
    cycle("R6 fetch miss", 32'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    write_reg(2'd2, 32'h20);
    cycle("R6 operand hit", 32'h0, 1'b0, 1'b1, 2'd0, 1'b1);
    cycle("R6 operand miss", 32'h0, 1'b1, 1'b0, 2'd0, 1'b0);
    write_reg(2'd2, 32'h04);
    cycle("R7 read hit", 32'h0, 1'b0, 1'b0, 2'd2, 1'b1);
    cycle("R7 read miss", 32'h0, 1'b0, 1'b1, 2'd2, 1'b0);
    write_reg(2'd2, 32'h08);
    cycle("R7 write hit", 32'h0, 1'b0, 1'b1, 2'd2, 1'b1);
    cycle("R7 write miss", 32'h0, 1'b0, 1'b0, 2'd2, 1'b0);
    write_reg(2'd2, 32'h0C);
    cycle("R7 either", 32'h0, 1'b1, 1'b1, 2'd0, 1'b1);
    write_reg(2'd2, 32'h02);
    cycle("R8 word hit", 32'h0, 1'b0, 1'b0, 2'd1, 1'b1);
    cycle("R8 word miss", 32'h0, 1'b0, 1'b0, 2'd2, 1'b0);
    write_reg(2'd2, 32'h40);
    cycle("R8 quad hit", 32'h0, 1'b0, 1'b0, 2'd3, 1'b1);
    cycle("R8 quad miss", 32'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    write_reg(2'd2, 32'h41);
    for (int s = 0; s < 4; s++)
      cycle("R8 code 101 never", 32'h0, 1'b0, 1'b0, 2'(s), 1'b0);
  endtask

  task automatic t_timing;
    write_reg(2'd1, 32'd3);
    write_reg(2'd2, 32'h30);
    @(negedge clk);
    bus_valid = 1'b0; bus_fetch = 1'b1;
    @(negedge clk);
    check("R9 no valid", {31'd0, brk_match}, 32'h0);
    bus_valid = 1'b1;
    @(negedge clk);
    check("R9 back-to-back 1", {31'd0, brk_match}, 32'h1);
    @(negedge clk);
    check("R9 back-to-back 2", {31'd0, brk_match}, 32'h1);
    bus_valid = 1'b0;
    @(negedge clk);
    check("R9 single pulse end", {31'd0, brk_match}, 32'h0);
  endtask

  task automatic t_same_clock;
    write_reg(2'd1, 32'd3);
    write_reg(2'd2, 32'h10);
    @(negedge clk);
    bus_valid = 1'b1; bus_fetch = 1'b1; bus_write = 1'b0; bus_size = 2'd0;
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h20;
    @(negedge clk);
    reg_we = 1'b0;
    check("R11 old setting used", {31'd0, brk_match}, 32'h1);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R11 new setting next", {31'd0, brk_match}, 32'h0);
    // refused mask write in the same clock as an address-dependent cycle
    write_reg(2'd0, BASE);
    write_reg(2'd2, 32'h30);
    write_reg(2'd1, 32'd1);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = BASE ^ 32'h3FF;
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'd6;
    @(negedge clk);
    reg_we = 1'b0;
    check("R11 same clock refused", {31'd0, brk_match}, 32'h1);
    bus_addr = BASE ^ 32'hFFF;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R5 R11 mask kept after", {31'd0, brk_match}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_disabled();
    t_masks();
    t_refused();
    t_fields();
    t_timing();
    t_same_clock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule